// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves byte-wide channels between serial TDM streams. All input and output streams share one frame timing. A frame is a fixed number of channel slots, and each clock cycle is one slot. In every slot the block stores the byte arriving on each input stream in a data memory. The data memory has three frame banks used in rotation, so the bank being filled is never the bank being read.

Each output stream and slot has its own entry in a connection memory. The entry gives the channel one of four behaviours:
- switch a stored byte from any input stream and channel;
- send the entry's own message byte;
- drive all ones;
- release the line (output enable low).

Switched bytes always leave exactly two frames after they arrived, whatever the input and output slot positions are. This keeps the bytes of one frame together.

A small register port writes and reads back connection memory and reads data memory. Connection memory writes go into a shadow copy. The shadow is copied into the working map at the frame boundary, so a frame is never switched with a map that is only partly updated.

Top module: `tsi_switch`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `out_data`, `out_oe` and `out_sof` are all zero. After reset every connection memory word reads back as zero, which means switch mode from stream 0 channel 0.
- R2: Consider a word in switch mode at output stream o, slot d. The output for slot d of frame F (F ≥ 2) carries the byte that was received on the word's source stream and source channel during frame F−2, with `out_oe` = 1. This holds for any order of source and destination slots.
- R3: The data memory is cleared by reset. A switch-mode channel therefore outputs 0x00 with `out_oe` = 1 during the first two frames after reset.
- R4: In message mode (mode code 01) the output carries the word's message byte with `out_oe` = 1.
- R5: In drive-high mode (mode code 10) the output carries 0xFF with `out_oe` = 1.
- R6: In release mode (mode code 11) `out_oe` is 0 and the lane's `out_data` byte is 0x00.
- R7: A connection memory write accepted in a cycle whose input slot is not the last slot of the frame takes effect from slot 0 of the next output frame. The frame in progress keeps the old map.
- R8: `in_sof` is high exactly when the slot being sampled is slot 0. `out_sof` is high exactly when the output presents slot 0, one cycle later. Both repeat every 32 cycles.
- R9: A read with `cpu_addr[7]` = 0 returns, one cycle later on `cpu_rdata`, the shadow connection word at output stream `cpu_addr[6:5]`, slot `cpu_addr[4:0]`. The word layout is: [16:15] mode (00 switch, 01 message, 10 drive-high, 11 release), [14:7] message byte, [6:2] source channel, [1:0] source stream. `cpu_rdata` holds its value in cycles without a read.
- R10: A read with `cpu_addr[7]` = 1 returns, zero-extended and one cycle later, the byte received on stream `cpu_addr[6:5]`, channel `cpu_addr[4:0]` during the last completed input frame.
- R11: A write with `cpu_addr[7]` = 1 changes neither data memory nor connection memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one channel slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 32 | Input bytes, stream s at bits [8s+7:8s] |
| in_sof | output | 1 | High when the slot being sampled is slot 0 |
| out_data | output | 32 | Output bytes, stream s at bits [8s+7:8s] |
| out_oe | output | 4 | Per-stream output enable for the current output slot |
| out_sof | output | 1 | High when the outputs present slot 0 |
| cpu_wr | input | 1 | Register port write strobe |
| cpu_rd | input | 1 | Register port read strobe |
| cpu_addr | input | 8 | [7] memory select, [6:5] stream, [4:0] channel |
| cpu_wdata | input | 17 | Connection word to write |
| cpu_rdata | output | 17 | Read result, valid the cycle after a read |

## Verification
The bench builds the block with the package defaults: four streams, 32 slots per frame and three banks. With these values a complete frame of every output lane can be compared against a model in 32 cycles. Runs therefore cover the two cleared frames after reset, mirrored and reversed slot mappings, and maps rewritten across several frame boundaries, all within a few hundred cycles. Each input byte encodes its stream, channel and frame number. A byte taken from the wrong frame or the wrong slot therefore shows up as a mismatch.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int ST_N   = 4;
    localparam int CH_N   = 32;
    localparam int BYTE_W = 8;
    localparam int BANKS  = 3;

    localparam int ST_W   = $clog2(ST_N);
    localparam int CH_W   = $clog2(CH_N);
    localparam int CM_AW  = ST_W + CH_W;
    localparam int CPU_AW = CM_AW + 1;
    localparam int BANK_W = $clog2(BANKS);

    typedef enum logic [1:0] {
        M_SWITCH = 2'b00,
        M_MSG    = 2'b01,
        M_HIGH   = 2'b10,
        M_HIZ    = 2'b11
    } chmode_e;

    typedef struct packed {
        chmode_e           mode;
        logic [BYTE_W-1:0] msg;
        logic [CH_W-1:0]   ch;
        logic [ST_W-1:0]   st;
    } cm_word_t;

    localparam int CMW = $bits(cm_word_t);

    function automatic logic [BANK_W-1:0] bank_next(input logic [BANK_W-1:0] b);
        return (b == BANK_W'(BANKS - 1)) ? '0 : b + 1'b1;
    endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [CH_W-1:0]   slot,
    output logic [BANK_W-1:0] wbank,
    output logic              frame_end
);
    assign frame_end = (slot == CH_W'(CH_N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            slot  <= '0;
            wbank <= '0;
        end else if (frame_end) begin
            slot  <= '0;
            wbank <= bank_next(wbank);
        end else begin
            slot  <= slot + 1'b1;
        end
    end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
    import tsi_pkg::*;
#(
    parameter int RD_PORTS = ST_N
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [BANK_W-1:0]                  wr_bank,
    input  logic [CH_W-1:0]                    wr_ch,
    input  logic [ST_N-1:0][BYTE_W-1:0]        wr_bytes,
    input  logic [BANK_W-1:0]                  sw_bank,
    input  logic [RD_PORTS-1:0][ST_W-1:0]      sw_st,
    input  logic [RD_PORTS-1:0][CH_W-1:0]      sw_ch,
    output logic [RD_PORTS-1:0][BYTE_W-1:0]    sw_q,
    input  logic [BANK_W-1:0]                  cpu_bank,
    input  logic [ST_W-1:0]                    cpu_st,
    input  logic [CH_W-1:0]                    cpu_ch,
    output logic [BYTE_W-1:0]                  cpu_q
);
    logic [BYTE_W-1:0] mem [BANKS][ST_N][CH_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < BANKS; b++)
                for (int s = 0; s < ST_N; s++)
                    for (int c = 0; c < CH_N; c++)
                        mem[b][s][c] <= '0;
        end else begin
            for (int s = 0; s < ST_N; s++)
                mem[wr_bank][s][wr_ch] <= wr_bytes[s];
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign sw_q[p] = mem[sw_bank][sw_st[p]][sw_ch[p]];
    end

    assign cpu_q = mem[cpu_bank][cpu_st][cpu_ch];
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
    import tsi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CM_AW-1:0]      wr_addr,
    input  cm_word_t              wr_word,
    input  logic                  load,
    input  logic [CH_W-1:0]       slot,
    input  logic [CM_AW-1:0]      rd_addr,
    output cm_word_t [ST_N-1:0]   cur,
    output cm_word_t              rd_word
);
    localparam int DEPTH = ST_N * CH_N;

    cm_word_t shadow [DEPTH];
    cm_word_t active [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                shadow[i] <= '0;
                active[i] <= '0;
            end
        end else begin
            if (wr_en)
                shadow[wr_addr] <= wr_word;
            if (load)
                active <= shadow;
        end
    end

    for (genvar o = 0; o < ST_N; o++) begin : g_cur
        assign cur[o] = active[{ST_W'(o), slot}];
    end

    assign rd_word = shadow[rd_addr];
endmodule

// File: rtl/tsi_out_lane.sv
module tsi_out_lane
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cm_word_t          word,
    input  logic [BYTE_W-1:0] sw_byte,
    output logic [BYTE_W-1:0] q,
    output logic              oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q  <= '0;
            oe <= 1'b0;
        end else begin
            unique case (word.mode)
                M_HIZ: begin
                    q  <= '0;
                    oe <= 1'b0;
                end
                M_HIGH: begin
                    q  <= '1;
                    oe <= 1'b1;
                end
                M_MSG: begin
                    q  <= word.msg;
                    oe <= 1'b1;
                end
                default: begin
                    q  <= sw_byte;
                    oe <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ST_N*BYTE_W-1:0] in_data,
    output logic                   in_sof,
    output logic [ST_N*BYTE_W-1:0] out_data,
    output logic [ST_N-1:0]        out_oe,
    output logic                   out_sof,
    input  logic                   cpu_wr,
    input  logic                   cpu_rd,
    input  logic [CPU_AW-1:0]      cpu_addr,
    input  logic [CMW-1:0]         cpu_wdata,
    output logic [CMW-1:0]         cpu_rdata
);
    logic [CH_W-1:0]   slot;
    logic [BANK_W-1:0] wbank;
    logic              frame_end;

    tsi_frame_timer u_tmr (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .wbank     (wbank),
        .frame_end (frame_end)
    );

    assign in_sof = (slot == '0);

    // Bank rotation: write f%3, switch reads frame f-2, port reads frame f-1
    logic [BANK_W-1:0] sw_bank, prev_bank;
    assign sw_bank   = bank_next(wbank);
    assign prev_bank = bank_next(sw_bank);

    logic     dm_sel;
    cm_word_t cm_rd;
    cm_word_t [ST_N-1:0] cur_w;
    assign dm_sel = cpu_addr[CM_AW];

    tsi_conn_mem u_cm (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cpu_wr && !dm_sel),
        .wr_addr (cpu_addr[CM_AW-1:0]),
        .wr_word (cm_word_t'(cpu_wdata)),
        .load    (frame_end),
        .slot    (slot),
        .rd_addr (cpu_addr[CM_AW-1:0]),
        .cur     (cur_w),
        .rd_word (cm_rd)
    );

    logic [ST_N-1:0][ST_W-1:0]   sw_st;
    logic [ST_N-1:0][CH_W-1:0]   sw_ch;
    logic [ST_N-1:0][BYTE_W-1:0] sw_q;
    logic [BYTE_W-1:0]           dm_q;

    tsi_data_mem #(.RD_PORTS(ST_N)) u_dm (
        .clk      (clk),
        .rst      (rst),
        .wr_bank  (wbank),
        .wr_ch    (slot),
        .wr_bytes (in_data),
        .sw_bank  (sw_bank),
        .sw_st    (sw_st),
        .sw_ch    (sw_ch),
        .sw_q     (sw_q),
        .cpu_bank (prev_bank),
        .cpu_st   (cpu_addr[CM_AW-1:CH_W]),
        .cpu_ch   (cpu_addr[CH_W-1:0]),
        .cpu_q    (dm_q)
    );

    for (genvar o = 0; o < ST_N; o++) begin : g_lane
        assign sw_st[o] = cur_w[o].st;
        assign sw_ch[o] = cur_w[o].ch;

        tsi_out_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .word    (cur_w[o]),
            .sw_byte (sw_q[o]),
            .q       (out_data[o*BYTE_W +: BYTE_W]),
            .oe      (out_oe[o])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sof   <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            out_sof <= in_sof;
            if (cpu_rd)
                cpu_rdata <= dm_sel ? CMW'(dm_q) : cm_rd;
        end
    end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
    import tsi_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   in_sof,
    input logic                   out_sof,
    input logic [ST_N-1:0]        out_oe,
    input logic [ST_N*BYTE_W-1:0] out_data,
    input logic                   cpu_rd,
    input logic [CMW-1:0]         cpu_rdata
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (out_oe == '0 && out_sof == 1'b0 && out_data == '0));

    // R8
    in_sof_single_chk: assert property (@(posedge clk) disable iff (rst)
        in_sof |=> !in_sof);

    // R8
    out_sof_align_chk: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> $past(in_sof));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |=> $stable(cpu_rdata));

    for (genvar o = 0; o < ST_N; o++) begin : g_lane_chk
        // R6
        released_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !out_oe[o] |-> (out_data[o*BYTE_W +: BYTE_W] == '0));
    end
endmodule

bind tsi_switch tsi_switch_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_sof    (in_sof),
    .out_sof   (out_sof),
    .out_oe    (out_oe),
    .out_data  (out_data),
    .cpu_rd    (cpu_rd),
    .cpu_rdata (cpu_rdata)
);

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
    import tsi_pkg::*;

    localparam int CLK_P = 10;
    localparam int NCFG  = 10;
    localparam int CFG_W = CM_AW + CMW;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [ST_N*BYTE_W-1:0] in_data = '0;
    logic                   in_sof;
    logic [ST_N*BYTE_W-1:0] out_data;
    logic [ST_N-1:0]        out_oe;
    logic                   out_sof;
    logic                   cpu_wr = 1'b0;
    logic                   cpu_rd = 1'b0;
    logic [CPU_AW-1:0]      cpu_addr = '0;
    logic [CMW-1:0]         cpu_wdata = '0;
    logic [CMW-1:0]         cpu_rdata;

    tsi_switch u0 (
        .clk(clk), .rst(rst), .in_data(in_data), .in_sof(in_sof),
        .out_data(out_data), .out_oe(out_oe), .out_sof(out_sof),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int bcyc  = 0;

    function automatic logic [CFG_W-1:0] mk(input int o, input int c, input chmode_e m,
                                            input int msg, input int sc, input int ss);
        cm_word_t w;
        w.mode = m;
        w.msg  = BYTE_W'(msg);
        w.ch   = CH_W'(sc);
        w.st   = ST_W'(ss);
        return {ST_W'(o), CH_W'(c), w};
    endfunction

    localparam logic [CFG_W-1:0] CFG [NCFG] = '{
        mk(0, 0,  M_SWITCH, 0,     31, 3),
        mk(0, 31, M_SWITCH, 0,     0,  1),
        mk(0, 5,  M_SWITCH, 0,     5,  0),
        mk(1, 2,  M_MSG,    'hA5,  0,  0),
        mk(1, 3,  M_HIGH,   0,     0,  0),
        mk(1, 4,  M_HIZ,    'h11,  9,  2),
        mk(2, 10, M_SWITCH, 0,     20, 2),
        mk(2, 20, M_SWITCH, 0,     10, 2),
        mk(3, 7,  M_MSG,    'h3C,  0,  0),
        mk(3, 8,  M_HIZ,    0,     0,  0)
    };

    function automatic logic [BYTE_W-1:0] pat(input int s, input int c, input int f);
        return BYTE_W'(s * 32 + c + f * 7);
    endfunction

    cm_word_t shadow_m [ST_N][CH_N];
    cm_word_t snap_m   [ST_N][CH_N];
    cm_word_t act_m    [ST_N][CH_N];

    initial begin
        for (int o = 0; o < ST_N; o++)
            for (int c = 0; c < CH_N; c++) begin
                shadow_m[o][c] = '0;
                snap_m[o][c]   = '0;
                act_m[o][c]    = '0;
            end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, bcyc);
        end
    endtask

    function automatic logic [8:0] model_out(input cm_word_t w, input int fr);
        case (w.mode)
            M_HIZ:   return {1'b0, 8'h00};
            M_HIGH:  return {1'b1, 8'hFF};
            M_MSG:   return {1'b1, w.msg};
            default: return {1'b1, (fr >= 2) ? pat(int'(w.st), int'(w.ch), fr - 2) : 8'h00};
        endcase
    endfunction

    // bench slot count and frame-boundary snapshot of the map
    always @(posedge clk) begin
        if (!rst) begin
            if (bcyc % CH_N == CH_N - 1)
                snap_m = shadow_m;
            bcyc++;
        end
    end

    // input pattern for the next sampling edge
    always @(negedge clk) begin
        for (int s = 0; s < ST_N; s++)
            in_data[s*BYTE_W +: BYTE_W] = pat(s, bcyc % CH_N, bcyc / CH_N);
    end

    // continuous output model compare
    always @(negedge clk) begin
        int k, fr, d;
        if (!rst) begin
            chk("R8 in_sof", 32'(in_sof), 32'(bcyc % CH_N == 0));
            if (bcyc >= 1) begin
                k  = bcyc - 1;
                fr = k / CH_N;
                d  = k % CH_N;
                if (d == 0)
                    act_m = snap_m;
                chk("R8 out_sof", 32'(out_sof), 32'(d == 0));
                for (int o = 0; o < ST_N; o++) begin
                    string tag;
                    case (act_m[o][d].mode)
                        M_HIZ:   tag = "R6 release, map per R7";
                        M_HIGH:  tag = "R5 drive-high, map per R7";
                        M_MSG:   tag = "R4 message, map per R7";
                        default: tag = (fr >= 2) ? "R2 switch, map per R7" : "R3 cleared";
                    endcase
                    chk(tag, 32'({out_oe[o], out_data[o*BYTE_W +: BYTE_W]}),
                        32'(model_out(act_m[o][d], fr)));
                end
            end
        end
    end

    task automatic cpu_write(input logic [CPU_AW-1:0] a, input logic [CMW-1:0] wd);
        @(negedge clk);
        while (bcyc % CH_N == CH_N - 1) @(negedge clk);
        cpu_wr    = 1'b1;
        cpu_addr  = a;
        cpu_wdata = wd;
        @(posedge clk);
        #1;
        if (!a[CM_AW])
            shadow_m[a[CM_AW-1:CH_W]][a[CH_W-1:0]] = cm_word_t'(wd);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [CPU_AW-1:0] a, output logic [CMW-1:0] q, output int j);
        @(negedge clk);
        j        = bcyc;
        cpu_rd   = 1'b1;
        cpu_addr = a;
        @(posedge clk);
        #1;
        cpu_rd = 1'b0;
        @(negedge clk);
        q = cpu_rdata;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [CMW-1:0] q;
        int j;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset oe", 32'(out_oe), 32'(0));
        chk("R1 reset data", out_data, 32'(0));
        chk("R1 reset sof", 32'(out_sof), 32'(0));
        rst = 1'b0;

        cpu_read({1'b0, 2'd2, 5'd9}, q, j);
        chk("R1 map cleared", 32'(q), 32'(0));

        // table of connection entries, then outputs are watched by the model
        for (int i = 0; i < NCFG; i++)
            cpu_write({1'b0, CFG[i][CFG_W-1:CMW]}, CFG[i][CMW-1:0]);

        cpu_read({1'b0, 2'd1, 5'd2}, q, j);
        chk("R9 readback msg word", 32'(q), 32'(CFG[3][CMW-1:0]));
        repeat (3) @(negedge clk);
        chk("R9 rdata hold", 32'(cpu_rdata), 32'(CFG[3][CMW-1:0]));
        cpu_read({1'b0, 2'd2, 5'd20}, q, j);
        chk("R9 readback switch word", 32'(q), 32'(CFG[7][CMW-1:0]));

        repeat (2 * CH_N) @(negedge clk);

        // data memory readback
        cpu_read({1'b1, 2'd2, 5'd13}, q, j);
        chk("R10 data read", 32'(q), 32'(pat(2, 13, j / CH_N - 1)));
        cpu_read({1'b1, 2'd3, 5'd0}, q, j);
        chk("R10 data read ch0", 32'(q), 32'(pat(3, 0, j / CH_N - 1)));

        // write aimed at data memory is dropped
        cpu_write({1'b1, 2'd2, 5'd13}, 17'h1FFFF);
        cpu_read({1'b1, 2'd2, 5'd13}, q, j);
        chk("R11 data unchanged", 32'(q), 32'(pat(2, 13, j / CH_N - 1)));
        cpu_read({1'b0, 2'd2, 5'd13}, q, j);
        chk("R11 map unchanged", 32'(q), 32'(0));

        // mid-frame rewrite: old map holds until the boundary
        while (bcyc % CH_N != 2) @(negedge clk);
        cpu_write({1'b0, 2'd3, 5'd20}, mk(0, 0, M_MSG, 'h77, 0, 0));

        // full reversed map on stream 2, spread across frame boundaries
        for (int c = 0; c < CH_N; c++)
            cpu_write({1'b0, 2'd2, CH_W'(c)}, mk(0, 0, M_SWITCH, 0, CH_N - 1 - c, c % ST_N));

        repeat (4 * CH_N) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule